// File: doc/BRIEF.md
# Byte-Buffered I2C Bus Master

This block is an I2C bus master that moves one byte at a time between a single processor-side buffer register and the two-wire bus. SCL and SDA are driven through open-drain enables, where 1 means pull the line low, and both lines are read back. The processor loads the buffer, then pulses a go strobe. With the go strobe it gives three flags: begin with a START, end with a STOP, and the acknowledge to return on a read byte. The first byte after a START is the address byte: the 7-bit target address in bits 7..1 and the direction in bit 0, where 1 means read.

After each byte and its acknowledge slot, the master parks the bus with SCL held low until the processor services the buffer. For a written byte, `tx_empty_irq` rises and the processor writes the next byte and pulses go. For a read byte, `rx_full_irq` rises and the processor reads the byte and pulses go. The length of each SCL phase is a fixed number of 30 ns base ticks: 167 in standard mode and 47 in fast mode. The parameter `TICK_CLKS` sets how many system clocks make one base tick.

The state machine has twelve states:
- IDLE moves to START on a go strobe carrying a start request.
- START moves to BIT_LO.
- BIT_LO and BIT_HI alternate for each bit. After the eighth bit, BIT_HI moves to ACK_LO, then ACK_HI, then HOLD.
- HOLD leaves when a go strobe is pending and no received byte is unread:
  - to STOP_LO, then STOP_HI, then STOP_END, then IDLE, on a stop request;
  - to RS_LO, then RS_HI, then START, on a start request;
  - to BIT_LO for a plain next byte.
- While the error flag is set, a plain go in HOLD is discarded.
- Every state except IDLE and HOLD lasts one phase.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, both open-drain enables are 0 (lines released), and `tx_empty_irq`, `rx_full_irq` and `bus_err` are 0.
- R2: A go strobe with `want_start`=1 from idle pulls SDA low while SCL stays released for one phase. The buffer is then shifted out as the address byte.
- R3: Bytes are shifted MSB first, one bit per SCL pulse. SDA only changes while SCL is low, except for the fall at START and the rise at STOP.
- R4: Each SCL low or high phase lasts `TICK_CLKS`×167 clocks, or `TICK_CLKS`×47 clocks when `fast_en`=1. If another device holds SCL low, the high phase is counted only from the moment the line is seen high.
- R5: `tx_empty_irq` rises when the acknowledge slot of a sent byte (address or write data) ends. It falls on a buffer write.
- R6: In HOLD, SCL is held low and no bits are sent until a go strobe arrives. A buffer write alone does not start a byte.
- R7: When address bit 0 is 1, the master releases SDA for the data bits and samples them. At the end of the acknowledge slot it copies the byte into the buffer and raises `rx_full_irq`. A buffer read strobe clears `rx_full_irq`.
- R8: In the acknowledge slot of a read byte, the master pulls SDA low if `nack_sel`=0 (ACK). It releases SDA if `nack_sel`=1 (NACK). The value used is the one given with the go strobe that started the byte.
- R9: After a read byte, the next byte does not start until both the buffer has been read and a go strobe has been given, in either order.
- R10: If SDA is high at the acknowledge sample of a sent byte, `bus_err` is set. While it is set, a go without a stop request is discarded and the bus stays held. A go with a stop request issues a STOP. `bus_err` clears at the next START from idle.
- R11: A go with `want_stop`=1 in HOLD produces three phases: SDA low with SCL low, then SCL released, then SDA released. Both lines then stay released.
- R12: A go with `want_start`=1 in HOLD releases SDA, then releases SCL, then issues a repeated START without a STOP. The buffer is then sent as a new address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_wr | input | 1 | Write strobe for the data buffer |
| buf_wdata | input | 8 | Byte written into the buffer |
| buf_rd | input | 1 | Read strobe; clears the receive-full flag |
| buf_rdata | output | 8 | Current buffer content |
| xfer_go | input | 1 | Go strobe; captures the three flags below |
| want_start | input | 1 | Issue a START (or repeated START) before the byte |
| want_stop | input | 1 | Issue a STOP instead of a byte |
| nack_sel | input | 1 | Acknowledge for a read byte: 0 ACK, 1 NACK |
| fast_en | input | 1 | 1 selects 47-tick phases, 0 selects 167-tick phases |
| tx_empty_irq | output | 1 | Sent byte finished its acknowledge slot |
| rx_full_irq | output | 1 | Received byte waiting in the buffer |
| bus_err | output | 1 | Target did not acknowledge a sent byte |
| scl_oe | output | 1 | 1 pulls SCL low |
| scl_in | input | 1 | SCL line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | SDA line level |

## Verification
On every cycle, the bound checker covers the following:
- both lines are released in idle, and SCL is low in HOLD;
- SDA moves with SCL high only on entry to START and STOP_END;
- every BIT_LO phase lasts the number of clocks that the fast-mode bit asks for;
- the interrupt flags rise only at the end of an acknowledge slot of the right direction;
- an errored bus leaves HOLD only towards STOP.

Some behaviour can only be seen through the bench's scenarios, which run a target model on the wire:
- the bit order and the byte values seen on the wire;
- the acknowledge the master returns per `nack_sel`;
- the stall that lasts until both the buffer access and the go strobe have happened;
- the repeated START, and high phases that keep their length when a target holds SCL low.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_BIT_LO,
        S_BIT_HI,
        S_ACK_LO,
        S_ACK_HI,
        S_HOLD,
        S_STOP_LO,
        S_STOP_HI,
        S_STOP_END,
        S_RS_LO,
        S_RS_HI
    } bm_state_e;

    // base ticks per SCL phase
    localparam int STD_TICKS  = 167;
    localparam int FAST_TICKS = 47;

endpackage

// File: rtl/i2c_bm_phase_timer.sv
module i2c_bm_phase_timer #(
    parameter int TICK_CLKS  = 6,
    parameter int STD_TICKS  = 167,
    parameter int FAST_TICKS = 47
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic fast_en,
    input  logic freeze,
    output logic done
);
    localparam int STD_CLKS  = TICK_CLKS * STD_TICKS;
    localparam int FAST_CLKS = TICK_CLKS * FAST_TICKS;
    localparam int CW        = $clog2(STD_CLKS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= fast_en ? CW'(FAST_CLKS - 1) : CW'(STD_CLKS - 1);
        end else if (!freeze && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0) && !freeze;

endmodule

// File: rtl/i2c_bm_shifter.sv
module i2c_bm_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] ld_val,
    input  logic         shift,
    input  logic         ser_in,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= ld_val;
        end else if (shift) begin
            q <= {q[W-2:0], ser_in};
        end
    end

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2c_bm_pkg::*;
#(
    parameter int TICK_CLKS = 6,
    parameter int BYTE_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_wr,
    input  logic [BYTE_W-1:0] buf_wdata,
    input  logic              buf_rd,
    output logic [BYTE_W-1:0] buf_rdata,
    input  logic              xfer_go,
    input  logic              want_start,
    input  logic              want_stop,
    input  logic              nack_sel,
    input  logic              fast_en,
    output logic              tx_empty_irq,
    output logic              rx_full_irq,
    output logic              bus_err,
    output logic              scl_oe,
    input  logic              scl_in,
    output logic              sda_oe,
    input  logic              sda_in
);
    localparam int BW = $clog2(BYTE_W);

    bm_state_e         state, nxt;
    logic              go_pend, start_q, stop_q, nack_q;
    logic              rd_q, is_addr, tx_empty, rx_full, err_q;
    logic [BW-1:0]     bit_cnt;
    logic [BYTE_W-1:0] dbuf, sh;
    logic              done, restart, freeze;
    logic              tx_byte, ready, take_go, enter_start, byte_end, last_bit;
    logic              scl_oe_c, sda_oe_c;

    assign tx_byte     = is_addr || !rd_q;
    assign ready       = go_pend && !rx_full;
    assign last_bit    = (bit_cnt == BW'(BYTE_W - 1));
    assign restart     = (nxt != state);
    assign enter_start = (nxt == S_START) && (state != S_START);
    assign byte_end    = (state == S_ACK_HI) && done;
    assign take_go     = ((state == S_IDLE) && go_pend) || ((state == S_HOLD) && ready);
    assign freeze      = !scl_oe_c && !scl_in;

    i2c_bm_phase_timer #(
        .TICK_CLKS (TICK_CLKS),
        .STD_TICKS (STD_TICKS),
        .FAST_TICKS(FAST_TICKS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .fast_en(fast_en),
        .freeze (freeze),
        .done   (done)
    );

    i2c_bm_shifter #(.W(BYTE_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (enter_start || ((state == S_HOLD) && (nxt == S_BIT_LO))),
        .ld_val(dbuf),
        .shift ((state == S_BIT_HI) && done),
        .ser_in(sda_in),
        .q     (sh)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:     if (go_pend && start_q) nxt = S_START;
            S_START:    if (done) nxt = S_BIT_LO;
            S_BIT_LO:   if (done) nxt = S_BIT_HI;
            S_BIT_HI:   if (done) nxt = last_bit ? S_ACK_LO : S_BIT_LO;
            S_ACK_LO:   if (done) nxt = S_ACK_HI;
            S_ACK_HI:   if (done) nxt = S_HOLD;
            S_HOLD: begin
                if (ready) begin
                    if (stop_q)       nxt = S_STOP_LO;
                    else if (err_q)   nxt = S_HOLD;
                    else if (start_q) nxt = S_RS_LO;
                    else              nxt = S_BIT_LO;
                end
            end
            S_STOP_LO:  if (done) nxt = S_STOP_HI;
            S_STOP_HI:  if (done) nxt = S_STOP_END;
            S_STOP_END: if (done) nxt = S_IDLE;
            S_RS_LO:    if (done) nxt = S_RS_HI;
            S_RS_HI:    if (done) nxt = S_START;
            default:    nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // line drive
    always_comb begin
        scl_oe_c = 1'b0;
        sda_oe_c = 1'b0;
        unique case (state)
            S_START:               sda_oe_c = 1'b1;
            S_BIT_LO: begin
                scl_oe_c = 1'b1;
                sda_oe_c = tx_byte && !sh[BYTE_W-1];
            end
            S_BIT_HI:              sda_oe_c = tx_byte && !sh[BYTE_W-1];
            S_ACK_LO: begin
                scl_oe_c = 1'b1;
                sda_oe_c = !tx_byte && !nack_q;
            end
            S_ACK_HI:              sda_oe_c = !tx_byte && !nack_q;
            S_HOLD, S_RS_LO:       scl_oe_c = 1'b1;
            S_STOP_LO: begin
                scl_oe_c = 1'b1;
                sda_oe_c = 1'b1;
            end
            S_STOP_HI:             sda_oe_c = 1'b1;
            default: begin
                scl_oe_c = 1'b0;
                sda_oe_c = 1'b0;
            end
        endcase
    end

    assign scl_oe = scl_oe_c;
    assign sda_oe = sda_oe_c;

    // buffer, handshake flags and byte bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go_pend  <= 1'b0;
            start_q  <= 1'b0;
            stop_q   <= 1'b0;
            nack_q   <= 1'b0;
            rd_q     <= 1'b0;
            is_addr  <= 1'b0;
            tx_empty <= 1'b0;
            rx_full  <= 1'b0;
            err_q    <= 1'b0;
            bit_cnt  <= '0;
            dbuf     <= '0;
        end else begin
            if (xfer_go) begin
                go_pend <= 1'b1;
                start_q <= want_start;
                stop_q  <= want_stop;
                nack_q  <= nack_sel;
            end else if (take_go) begin
                go_pend <= 1'b0;
            end

            if (enter_start) begin
                rd_q    <= dbuf[0];
                is_addr <= 1'b1;
            end else if (byte_end) begin
                is_addr <= 1'b0;
            end

            if (enter_start)
                bit_cnt <= '0;
            else if ((state == S_BIT_HI) && done)
                bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;

            if (buf_wr)
                dbuf <= buf_wdata;
            else if (byte_end && !tx_byte)
                dbuf <= sh;

            if (byte_end && tx_byte) tx_empty <= 1'b1;
            else if (buf_wr)         tx_empty <= 1'b0;

            if (byte_end && !tx_byte) rx_full <= 1'b1;
            else if (buf_rd)          rx_full <= 1'b0;

            if ((state == S_IDLE) && enter_start) err_q <= 1'b0;
            else if (byte_end && tx_byte && sda_in) err_q <= 1'b1;
        end
    end

    assign buf_rdata    = dbuf;
    assign tx_empty_irq = tx_empty;
    assign rx_full_irq  = rx_full;
    assign bus_err      = err_q;

endmodule

// File: rtl/i2c_bm_checker.sv
module i2c_bm_checker
    import i2c_bm_pkg::*;
#(
    parameter int TICK_CLKS = 6
) (
    input logic      clk,
    input logic      rst_n,
    input bm_state_e state,
    input logic      scl_oe,
    input logic      sda_oe,
    input logic      fast_en,
    input logic      tx_empty_irq,
    input logic      rx_full_irq,
    input logic      bus_err,
    input logic      rd_q,
    input logic      is_addr
);
    bm_state_e   prev;
    logic        fast_d, fast_ph;
    logic [31:0] run_q, run_now;

    assign run_now = (state != prev) ? 32'd1 : run_q + 32'd1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev    <= S_IDLE;
            fast_d  <= 1'b0;
            fast_ph <= 1'b0;
            run_q   <= 32'd0;
        end else begin
            prev   <= state;
            fast_d <= fast_en;
            run_q  <= run_now;
            if (state != prev) fast_ph <= fast_d;
        end
    end

    p_idle_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> (!scl_oe && !sda_oe));

    p_sda_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && $past(!scl_oe) && $rose(sda_oe)) |-> (state == S_START));

    p_sda_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && $past(!scl_oe) && $fell(sda_oe)) |-> (state == S_STOP_END));

    p_low_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != prev) && (prev == S_BIT_LO)) |->
        (run_q == 32'((fast_ph ? FAST_TICKS : STD_TICKS) * TICK_CLKS)));

    p_tx_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty_irq) |-> (($past(state) == S_ACK_HI) && ($past(is_addr) || !$past(rd_q))));

    p_hold_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOLD) |-> scl_oe);

    p_rx_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full_irq) |-> (($past(state) == S_ACK_HI) && $past(rd_q) && !$past(is_addr)));

    p_rx_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_BIT_LO) && rd_q && !is_addr) |-> !sda_oe);

    p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_HOLD) && bus_err) |=> ((state == S_HOLD) || (state == S_STOP_LO)));

endmodule

bind i2c_byte_master i2c_bm_checker #(.TICK_CLKS(TICK_CLKS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .scl_oe      (scl_oe),
    .sda_oe      (sda_oe),
    .fast_en     (fast_en),
    .tx_empty_irq(tx_empty_irq),
    .rx_full_irq (rx_full_irq),
    .bus_err     (bus_err),
    .rd_q        (rd_q),
    .is_addr     (is_addr)
);

// File: tb/i2c_byte_master_bench.sv
`timescale 1ns/1ps
module i2c_byte_master_bench;
    localparam int TK   = 1;
    localparam int STDP = 167 * TK;
    localparam int FSTP = 47 * TK;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       buf_wr = 0, buf_rd = 0, xfer_go = 0;
    logic       want_start = 0, want_stop = 0, nack_sel = 0, fast_en = 0;
    logic [7:0] buf_wdata = 8'h00;
    logic [7:0] buf_rdata;
    logic       tx_empty_irq, rx_full_irq, bus_err, scl_oe, sda_oe;
    logic       stretch = 0, slv_low = 0;
    logic       scl_line, sda_line;

    always #2.5 clk = ~clk;

    assign scl_line = !(scl_oe || stretch);
    assign sda_line = !(sda_oe || slv_low);

    i2c_byte_master #(.TICK_CLKS(TK)) u_i2c_byte_master (
        .clk(clk), .rst_n(rst_n),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_rd(buf_rd), .buf_rdata(buf_rdata),
        .xfer_go(xfer_go), .want_start(want_start), .want_stop(want_stop),
        .nack_sel(nack_sel), .fast_en(fast_en),
        .tx_empty_irq(tx_empty_irq), .rx_full_irq(rx_full_irq), .bus_err(bus_err),
        .scl_oe(scl_oe), .scl_in(scl_line), .sda_oe(sda_oe), .sda_in(sda_line)
    );

    // ---------------- target model and wire monitor ----------------
    int         n_chk = 0, n_bad = 0;
    int         starts = 0, stops = 0, rises = 0, nbytes = 0;
    int         bitn = 0, hi_run = 0, hi_len = 0, hi_b4 = 0, stretch_cnt = 0, rd_idx = 0;
    logic       prev_scl = 1, prev_sda = 1, in_addr = 0, rd_dir = 0, cur_ack = 0, was_addr;
    logic       slv_nack = 0, stretch_arm = 0;
    logic [7:0] shb = 0;
    logic [7:0] byte_log [64];
    logic       ack_log  [64];
    logic [7:0] rd_pat   [4];

    always @(posedge clk) begin
        if (rst_n) begin
            if (stretch_cnt > 0) begin
                stretch_cnt = stretch_cnt - 1;
                if (stretch_cnt == 0) stretch = 0;
            end
            if (prev_scl && scl_line && prev_sda && !sda_line) begin
                starts = starts + 1; bitn = 0; in_addr = 1; rd_dir = 0; rd_idx = 0; slv_low = 0;
            end else if (prev_scl && scl_line && !prev_sda && sda_line) begin
                stops = stops + 1; slv_low = 0;
            end
            if (!prev_scl && scl_line) begin
                rises = rises + 1; hi_run = 0;
                if (bitn < 8) shb = {shb[6:0], sda_line};
                else cur_ack = sda_line;
                bitn = bitn + 1;
            end
            if (scl_line) hi_run = hi_run + 1;
            if (prev_scl && !scl_line) begin
                hi_len = hi_run;
                if (bitn == 4) hi_b4 = hi_run;
                if (bitn == 3 && stretch_arm) begin
                    stretch = 1; stretch_cnt = 80; stretch_arm = 0;
                end
                if (bitn == 8) begin
                    slv_low = (in_addr || !rd_dir) ? !slv_nack : 1'b0;
                    if (in_addr) rd_dir = shb[0];
                end else if (bitn == 9) begin
                    byte_log[nbytes % 64] = shb;
                    ack_log[nbytes % 64]  = cur_ack;
                    nbytes = nbytes + 1; bitn = 0;
                    was_addr = in_addr; in_addr = 0;
                    if (!was_addr && rd_dir) rd_idx = rd_idx + 1;
                    if (rd_dir && !(!was_addr && cur_ack)) slv_low = !rd_pat[rd_idx % 4][7];
                    else slv_low = 0;
                end else if (bitn >= 1 && bitn <= 7 && rd_dir && !in_addr) begin
                    slv_low = !rd_pat[rd_idx % 4][7 - bitn];
                end
            end
            prev_scl = scl_line; prev_sda = sda_line;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic go(input logic s, input logic p, input logic n);
        @(negedge clk);
        xfer_go = 1; want_start = s; want_stop = p; nack_sel = n;
        @(negedge clk);
        xfer_go = 0; want_start = 0; want_stop = 0;
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk); buf_wr = 1; buf_wdata = b;
        @(negedge clk); buf_wr = 0;
    endtask

    task automatic rd();
        @(negedge clk); buf_rd = 1;
        @(negedge clk); buf_rd = 0;
    endtask

    task automatic wait_tx();
        do @(negedge clk); while (!tx_empty_irq);
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_rx();
        do @(negedge clk); while (!rx_full_irq);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_stop();
        int s0 = stops;
        go(0, 1, 0);
        do @(negedge clk); while (stops == s0);
        check("R11 stop seen", stops, s0 + 1);
        check("R11 scl released", scl_oe, 0);
        check("R11 sda released", sda_oe, 0);
        repeat (3 * STDP) @(negedge clk);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk = n_chk + 1; n_bad = n_bad + 1;
        $display("FAIL watchdog act=hung exp=done");
        summary();
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        logic [7:0] wdat [8];
        int s0, r0;
        wdat = '{8'hA5, 8'h3C, 8'h00, 8'hFF, 8'h81, 8'h7E, 8'h01, 8'h80};
        rd_pat = '{8'hC3, 8'h5A, 8'h01, 8'hFE};

        repeat (10) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 scl_oe", scl_oe, 0);
        check("R1 sda_oe", sda_oe, 0);
        check("R1 tx_empty", tx_empty_irq, 0);
        check("R1 rx_full", rx_full_irq, 0);
        check("R1 bus_err", bus_err, 0);

        // fast-mode write sweep
        fast_en = 1;
        wr({7'h2C, 1'b0});
        s0 = starts;
        go(1, 0, 0);
        wait_tx();
        check("R2 start count", starts, s0 + 1);
        check("R2 address byte", byte_log[(nbytes - 1) % 64], 8'h58);
        check("R5 address acked", ack_log[(nbytes - 1) % 64], 0);
        check("R5 tx_empty set", tx_empty_irq, 1);
        check("R4 fast high phase", hi_len, FSTP);
        for (int i = 0; i < 8; i++) begin
            r0 = rises;
            repeat (300) @(negedge clk);
            check("R6 held scl low", scl_oe, 1);
            check("R6 no pulses while waiting", rises, r0);
            wr(wdat[i]);
            check("R5 tx_empty cleared by write", tx_empty_irq, 0);
            repeat (300) @(negedge clk);
            check("R6 write alone starts nothing", rises, r0);
            if (i == 2) stretch_arm = 1;
            go(0, 0, 0);
            wait_tx();
            check("R3 data byte on wire", byte_log[(nbytes - 1) % 64], wdat[i]);
            if (i == 2) check("R4 high phase after stretch", hi_b4, FSTP);
        end
        do_stop();

        // standard-mode write, then repeated START into a read
        fast_en = 0;
        wr({7'h19, 1'b0});
        go(1, 0, 0);
        wait_tx();
        check("R4 standard high phase", hi_len, STDP);
        wr(8'h77);
        go(0, 0, 0);
        wait_tx();
        check("R3 standard data byte", byte_log[(nbytes - 1) % 64], 8'h77);
        s0 = starts; r0 = stops;
        wr({7'h19, 1'b1});
        go(1, 0, 0);
        wait_tx();
        check("R12 repeated start", starts, s0 + 1);
        check("R12 no stop between", stops, r0);
        check("R12 read address", byte_log[(nbytes - 1) % 64], 8'h33);

        fast_en = 1;
        go(0, 0, 0);
        for (int i = 0; i < 4; i++) begin
            wait_rx();
            check("R7 received byte", buf_rdata, rd_pat[i]);
            check("R8 master ack value", ack_log[(nbytes - 1) % 64], (i == 3) ? 1 : 0);
            r0 = rises;
            repeat (200) @(negedge clk);
            check("R9 held until read", rises, r0);
            if (i < 3) begin
                go(0, 0, (i + 1) == 3);
                repeat (200) @(negedge clk);
                check("R9 go without read waits", rises, r0);
                rd();
                check("R7 rx_full cleared by read", rx_full_irq, 0);
            end else begin
                rd();
            end
        end
        do_stop();

        // target refuses the address
        slv_nack = 1;
        wr({7'h11, 1'b0});
        go(1, 0, 0);
        wait_tx();
        check("R10 nack seen on wire", ack_log[(nbytes - 1) % 64], 1);
        check("R10 bus_err set", bus_err, 1);
        wr(8'h42);
        go(0, 0, 0);
        r0 = rises;
        repeat (400) @(negedge clk);
        check("R10 plain go discarded", rises, r0);
        check("R10 bus held", scl_oe, 1);
        do_stop();
        slv_nack = 0;
        wr({7'h11, 1'b0});
        go(1, 0, 0);
        wait_tx();
        check("R10 bus_err cleared by new start", bus_err, 0);
        do_stop();

        summary();
        $finish;
    end

endmodule